// File: doc/BRIEF.md
# Host Parallel Bus Interface for a Converter Pair

This block sits between a microprocessor's asynchronous parallel bus and the digital side of a combined ADC/DAC front end. It takes the host's chip-select, read strobe, write strobe and an 8-bit write data bus into a system clock domain. From them it keeps an 8-bit DAC code register and presents the latest ADC result on the read data lines. It also owns the active-low interrupt flag that tells the host a conversion has finished.

A conversion sequencer outside this block signals `conv_busy_i` while it converts. It pulses `conv_done_i` for one clock with the new result. The host writes the DAC code by raising WR while CS is low. It reads the result by pulling CS and RD low, and it clears the interrupt by releasing CS or RD. The active-low reset clears the DAC code and the interrupt at once, without waiting for a clock edge. The result latch and any conversion in progress are not affected by that reset. The tri-state driver itself lives at the pad. This block supplies the read data and its output enable.

Top module: `host_bus_if`

## Requirements
- R1: Synchronizer timing and write capture. Call sample k the values the clock edge k sees on `cs_ni`, `wr_ni` and `bus_data_i`. If sample k is the first sample with `wr_ni` high after a low one, and `cs_ni` is low in sample k, then `dac_code_o` takes `bus_data_i` of sample k after clock edge k+2. Bit 7 is the MSB.
- R2: A rising WR whose sample k has `cs_ni` high leaves `dac_code_o` unchanged.
- R3: While `cs_ni` and `wr_ni` stay low, changes on `bus_data_i` leave `dac_code_o` unchanged.
- R4: Driving `rst_ni` low sets `dac_code_o` to 0 and `int_no` to 1 at once, without a clock edge. The DAC code stays 0 until the next accepted write.
- R5: A `conv_done_i` pulse seen at clock edge k drives `int_no` low after edge k. At the same edge, `conv_result_i` goes into the read latch.
- R6: A rising edge of `cs_ni` or of `rd_ni` sets `int_no` high again, with the same sample-k-plus-two timing as R1. If `conv_done_i` is seen at that same edge, the interrupt stays low.
- R7: `bus_data_o` shows the result of the most recent completed conversion. It keeps showing that result while `conv_busy_i` is high and a new conversion runs.
- R8: `bus_oe_o` is high only while `cs_ni` and `rd_ni` are both low, and it follows those pins without a clock. `bus_data_o` is 0 whenever `bus_oe_o` is low.
- R9: A write accepted while `conv_busy_i` is high still loads the DAC code and sets `collision_o`. An accepted write while `conv_busy_i` is low clears `collision_o`. Reset also clears it.
- R10: A `conv_done_i` pulse that arrives while `rst_ni` is low is still captured into the read latch. `int_no` stays high during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Host reset, active low, asynchronous |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, captured on its rising edge |
| bus_data_i | input | 8 | Write data from the host bus |
| bus_data_o | output | 8 | Read data toward the pad driver |
| bus_oe_o | output | 1 | Pad output enable |
| conv_busy_i | input | 1 | Conversion in progress |
| conv_done_i | input | 1 | One-cycle end-of-conversion pulse |
| conv_result_i | input | 8 | Result that goes with conv_done_i |
| dac_code_o | output | 8 | DAC register contents |
| int_no | output | 1 | Conversion-complete flag, active low |
| collision_o | output | 1 | Last accepted write came during a conversion |

## Verification
The write path is tried four ways: a plain CS-low write, a WR pulse with CS high, a long CS/WR-low hold while the data bus wanders, and a write made during a busy conversion. Together these separate an edge-triggered load from a level-triggered one, and a gated load from an ungated one. The interrupt is released once by an RD rise and once by a CS rise with RD still low. It is also tested with an end-of-conversion pulse that lands on the same edge as a release, to show which event wins. Asynchronous reset is applied in the middle of a clock period and checked before the next edge. A completion pulse is given inside a reset window, to show that the read latch does not depend on reset.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CTL_W       = 3;

  // control bit positions in the synchronized vector
  localparam int unsigned CTL_CS = 0;
  localparam int unsigned CTL_RD = 1;
  localparam int unsigned CTL_WR = 2;

  localparam logic [CTL_W-1:0] CTL_IDLE = '1;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hb_edge.sv
module hb_edge #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/hb_dac_reg.sv
module hb_dac_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         busy_i,
  output logic [W-1:0] code_o,
  output logic         coll_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_o <= '0;
      coll_o <= 1'b0;
    end else if (load_i) begin
      code_o <= data_i;
      coll_o <= busy_i;   // write still lands, flag records the overlap
    end
endmodule

// File: rtl/hb_read_port.sv
module hb_read_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  input  logic         release_i,
  input  logic         cs_ni,
  input  logic         rd_ni,
  output logic [W-1:0] data_o,
  output logic         oe_o,
  output logic         int_no
);
  logic [W-1:0] result_q;

  // host reset must not disturb conversion results
  always_ff @(posedge clk_i)
    if (done_i) result_q <= result_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        int_no <= 1'b1;
    else if (done_i)    int_no <= 1'b0;
    else if (release_i) int_no <= 1'b1;

  // enable straight from the pins: pad turnaround cannot wait for the synchronizer
  assign oe_o   = ~cs_ni & ~rd_ni;
  assign data_o = oe_o ? result_q : '0;
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import host_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  input  logic              conv_busy_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_result_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              int_no,
  output logic              collision_o
);
  logic [CTL_W-1:0]  ctl_raw, ctl_s, ctl_rise;
  logic [DATA_W-1:0] data_s;
  logic              wr_load, rel_evt;

  always_comb begin
    ctl_raw         = '0;
    ctl_raw[CTL_CS] = cs_ni;
    ctl_raw[CTL_RD] = rd_ni;
    ctl_raw[CTL_WR] = wr_ni;
  end

  hb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) i_ctl_sync (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s)
  );

  // data travels beside the strobes so it lines up with the WR edge
  hb_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_dat_sync (
    .clk_i, .rst_ni, .d_i(bus_data_i), .q_o(data_s)
  );

  hb_edge #(.W(CTL_W), .RST_VAL(CTL_IDLE)) i_ctl_edge (
    .clk_i, .rst_ni, .lvl_i(ctl_s), .rise_o(ctl_rise)
  );

  assign wr_load = ctl_rise[CTL_WR] & ~ctl_s[CTL_CS];
  assign rel_evt = ctl_rise[CTL_CS] | ctl_rise[CTL_RD];

  hb_dac_reg #(.W(DATA_W)) i_dac (
    .clk_i, .rst_ni,
    .load_i(wr_load), .data_i(data_s), .busy_i(conv_busy_i),
    .code_o(dac_code_o), .coll_o(collision_o)
  );

  hb_read_port #(.W(DATA_W)) i_rdp (
    .clk_i, .rst_ni,
    .done_i(conv_done_i), .result_i(conv_result_i), .release_i(rel_evt),
    .cs_ni, .rd_ni,
    .data_o(bus_data_o), .oe_o(bus_oe_o), .int_no
  );
endmodule

// File: rtl/host_bus_if_chk.sv
module host_bus_if_chk
  import host_bus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              conv_busy_i,
  input logic              conv_done_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] dac_code_o,
  input logic              int_no,
  input logic              collision_o,
  input logic              wr_load,
  input logic              rel_evt
);
  AST_DAC_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o != $past(dac_code_o)) |-> $past(wr_load)); // R3

  AST_INT_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> !int_no); // R5

  AST_INT_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_no) |-> ($past(rel_evt) && !$past(conv_done_i))); // R6

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && $past(bus_oe_o) && !$past(conv_done_i)) |-> $stable(bus_data_o)); // R7

  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!bus_oe_o && bus_data_o == '0)); // R8

  AST_COLLISION_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(collision_o) |-> ($past(conv_busy_i) && $past(wr_load))); // R9
endmodule

bind host_bus_if host_bus_if_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .conv_busy_i(conv_busy_i), .conv_done_i(conv_done_i),
  .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o),
  .dac_code_o(dac_code_o), .int_no(int_no), .collision_o(collision_o),
  .wr_load(wr_load), .rel_evt(rel_evt)
);

// File: tb/test_host_bus_if.sv
`timescale 1ns/1ps
module test_host_bus_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dbus = 8'h00;
  logic       busy = 1'b0, done = 1'b0;
  logic [7:0] res = 8'h00;
  logic [7:0] dout, dac;
  logic       oe, intn, coll;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  host_bus_if i_host_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .bus_data_i(dbus), .bus_data_o(dout), .bus_oe_o(oe),
    .conv_busy_i(busy), .conv_done_i(done), .conv_result_i(res),
    .dac_code_o(dac), .int_no(intn), .collision_o(coll)
  );

  // reference model: history of what each clock edge saw
  bit       h_cs[3], h_rd[3], h_wr[3];
  bit [7:0] h_d[3];
  logic [7:0] m_dac, m_res;
  logic       m_int, m_coll;
  bit         m_known = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        h_cs[i] = 1; h_rd[i] = 1; h_wr[i] = 1; h_d[i] = 0;
      end
      m_dac = 0; m_int = 1; m_coll = 0;
    end else begin
      if (h_wr[1] && !h_wr[2] && !h_cs[1]) begin
        m_dac = h_d[1]; m_coll = busy;
      end
      if (done) m_int = 0;
      else if ((h_cs[1] && !h_cs[2]) || (h_rd[1] && !h_rd[2])) m_int = 1;
      for (int i = 2; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_rd[i] = h_rd[i-1]; h_wr[i] = h_wr[i-1]; h_d[i] = h_d[i-1];
      end
      h_cs[0] = cs_n; h_rd[0] = rd_n; h_wr[0] = wr_n; h_d[0] = dbus;
    end
  end

  always @(posedge clk)
    if (done) begin m_res = res; m_known = 1; end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (!finished) begin
    check("R1 dac_code", {8'h0, dac}, {8'h0, m_dac});
    check("R5 int", {15'h0, intn}, {15'h0, m_int});
    check("R9 collision", {15'h0, coll}, {15'h0, m_coll});
    check("R8 oe", {15'h0, oe}, {15'h0, (!cs_n && !rd_n)});
    if (!cs_n && !rd_n && m_known) check("R7 read data", {8'h0, dout}, {8'h0, m_res});
    else if (!(!cs_n && !rd_n))    check("R8 idle data", {8'h0, dout}, 16'h0);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic host_write(logic [7:0] d, bit sel);
    cs_n = !sel; dbus = d; step();
    wr_n = 0; step();
    wr_n = 1; step(2);
    cs_n = 1; step(3);
  endtask

  task automatic conv(logic [7:0] r);
    busy = 1; step(3);
    res = r; done = 1; step();
    done = 0; busy = 0; step();
  endtask

  initial begin
    // R10: completion during reset is captured, int stays high
    step(2);
    res = 8'h5A; done = 1; step();
    done = 0; step();
    check("R10 int in reset", {15'h0, intn}, 16'h1);
    rst_n = 1; step(2);
    check("R4 dac after reset", {8'h0, dac}, 16'h0);
    cs_n = 0; rd_n = 0; step();
    check("R10 latched result", {8'h0, dout}, 16'h5A);
    rd_n = 1; cs_n = 1; step(4);

    // R1: plain writes, MSB on bit 7
    host_write(8'hA5, 1);
    check("R1 write A5", {8'h0, dac}, 16'hA5);
    host_write(8'h80, 1);
    check("R1 msb", {8'h0, dac}, 16'h80);

    // R2: CS high blocks the write
    host_write(8'h3C, 0);
    check("R2 cs high", {8'h0, dac}, 16'h80);

    // R3: data wanders while CS and WR held low
    cs_n = 0; wr_n = 0; step();
    for (int i = 0; i < 6; i++) begin dbus = 8'h11 * i[7:0]; step(); end
    check("R3 held", {8'h0, dac}, 16'h80);
    dbus = 8'h77; step();
    wr_n = 1; step(3);
    cs_n = 1; step(2);
    check("R3 load on rise", {8'h0, dac}, 16'h77);

    // R5/R7: conversion, then read during the next conversion
    conv(8'h81);
    check("R5 int low", {15'h0, intn}, 16'h0);
    busy = 1; cs_n = 0; rd_n = 0; step(2);
    check("R7 old data during busy", {8'h0, dout}, 16'h81);
    res = 8'hC3; step();
    check("R7 unchanged", {8'h0, dout}, 16'h81);
    // R6: RD rise releases INT
    rd_n = 1; step(3);
    check("R6 rd release", {15'h0, intn}, 16'h1);
    cs_n = 1; busy = 0; step(2);

    // R6: CS rise releases INT while RD stays low
    conv(8'h42);
    cs_n = 0; rd_n = 0; step(2);
    check("R7 new data", {8'h0, dout}, 16'h42);
    cs_n = 1; step(3);
    check("R6 cs release", {15'h0, intn}, 16'h1);
    rd_n = 1; step(2);

    // R6: done on the same edge as a release keeps INT low
    conv(8'h10);
    cs_n = 0; rd_n = 0; step(2);
    rd_n = 1; step(2);
    res = 8'h20; done = 1; step();
    done = 0; cs_n = 1; step();
    check("R6 done wins", {15'h0, intn}, 16'h0);
    step(3);

    // R9: write during conversion lands and flags; idle write clears
    busy = 1;
    host_write(8'hE7, 1);
    check("R9 busy write", {8'h0, dac}, 16'hE7);
    check("R9 flag set", {15'h0, coll}, 16'h1);
    busy = 0;
    host_write(8'h0F, 1);
    check("R9 flag clear", {15'h0, coll}, 16'h0);

    // R4: asynchronous reset mid-period
    conv(8'h99);
    @(posedge clk); #1;
    rst_n = 0; #0.5;
    check("R4 async dac", {8'h0, dac}, 16'h0);
    check("R4 async int", {15'h0, intn}, 16'h1);
    step(2);
    rst_n = 1; step(4);
    check("R4 dac stays zero", {8'h0, dac}, 16'h0);
    cs_n = 0; rd_n = 0; step();
    check("R10 result kept over reset", {8'h0, dout}, 16'h99);
    cs_n = 1; rd_n = 1; step(2);
    host_write(8'h5C, 1);
    check("R4 next write", {8'h0, dac}, 16'h5C);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule